// File: doc/BRIEF.md
# Dual-Mode Binary/BCD Adder

This block adds or subtracts two operands with a carry input and produces a result together with negative, overflow, zero and carry flags. A decimal-enable input selects either plain binary arithmetic or packed-BCD arithmetic. In packed BCD, each 4-bit digit holds a value from 0 to 9. Subtraction adds the inverted second operand and the carry input. For subtraction, the carry therefore means "no borrow".

A one-cycle start strobe launches an operation. The result and flags are registered, and a one-cycle done strobe marks the moment they become valid. A binary operation finishes one cycle after start. A decimal operation takes one further cycle, so that the negative and zero flags come from the corrected BCD result rather than from the raw binary sum. The width is set as a number of BCD digits, and the default is two digits (8 bits).

Top module: `dual_mode_adder`

## Requirements
- R1: While reset is held and after reset is released with no start, result, all four flags and done are 0.
- R2: A binary add (dec_en=0, sub_en=0) gives result = (opa + opb + carry_in) mod 256 and flag_c = bit 8 of that sum. done is high exactly in the cycle after the start cycle.
- R3: A binary subtract (sub_en=1) gives result = (opa + ~opb + carry_in) mod 256. flag_c=1 means no borrow occurred and flag_c=0 means a borrow occurred.
- R4: flag_v is the signed two's-complement overflow of opa plus the effective second operand (opb, or ~opb when subtracting) plus carry_in. In decimal mode it is taken from this binary sum before any correction.
- R5: flag_n equals bit 7 of the presented result and flag_z is 1 exactly when the presented result is 0. In decimal mode both come from the corrected BCD result.
- R6: A decimal add of valid BCD operands gives the BCD encoding of (opa + opb + carry_in) mod 100, with the high digit in bits 7:4. flag_c=1 when the decimal sum is 100 or more.
- R7: A decimal subtract of valid BCD operands gives opa − opb − (1 − carry_in). A negative value wraps by adding 100, and flag_c=0 exactly in that case.
- R8: A decimal operation raises done two cycles after its start cycle, and done stays low in the cycle between.
- R9: A start in the cycle right after a decimal start is ignored: no extra done pulse appears and the pending decimal result is presented unchanged.
- R10: Each accepted operation yields exactly one single-cycle done pulse. result and the flags hold their values in every cycle in which done is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle launch strobe |
| dec_en | input | 1 | 1 selects packed-BCD arithmetic |
| sub_en | input | 1 | 1 selects subtraction |
| carry_in | input | 1 | Carry in (inverted borrow when subtracting) |
| opa | input | 8 | First operand |
| opb | input | 8 | Second operand |
| result | output | 8 | Registered result |
| flag_n | output | 1 | Negative: bit 7 of result |
| flag_v | output | 1 | Signed overflow of the binary sum |
| flag_z | output | 1 | Result is zero |
| flag_c | output | 1 | Carry out, or no-borrow when subtracting |
| done | output | 1 | Result and flags valid this cycle |

## Verification
Binary operations are tried with pairs that overflow in the signed sense, wrap to zero, and borrow. These cases separate the carry flag from the overflow flag and show the inverted-borrow meaning of carry. Decimal operations are tried with sums that need a low-digit correction, a high-digit correction, or both. One case, 0x45 + 0x35, gives a corrected result with bit 7 set although the raw binary sum has it clear, which shows that the negative flag comes from the corrected value. A batch of random valid BCD operands in all four mode combinations is compared against decimal integer arithmetic. A start placed in the busy cycle shows whether a second request can corrupt or duplicate the pending decimal result.

// File: rtl/dma_pkg.sv
package dma_pkg;
   typedef struct packed {
      logic n;
      logic v;
      logic z;
      logic c;
   } dma_flags_t;

   localparam int unsigned DMA_DIGIT_W = 4;
   localparam int unsigned DMA_DIGIT_MAX = 9;
   localparam int unsigned DMA_DIGIT_ADJ = 6;
endpackage

// File: rtl/dma_bin_sum.sv
module dma_bin_sum #(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b_eff,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout,
   output logic         ovf
);
   logic [W:0] full;

   always_comb begin
      full = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
      sum  = full[W-1:0];
      cout = full[W];
      // signed overflow: like-signed inputs, result sign differs
      ovf  = (a[W-1] == b_eff[W-1]) && (full[W-1] != a[W-1]);
   end
endmodule

// File: rtl/dma_digit_fix.sv
module dma_digit_fix
   import dma_pkg::*;
(
   input  logic [DMA_DIGIT_W-1:0] a,
   input  logic [DMA_DIGIT_W-1:0] b_eff,
   input  logic                   cin,
   input  logic                   sub,
   output logic [DMA_DIGIT_W-1:0] digit,
   output logic                   cout
);
   logic [DMA_DIGIT_W:0] raw;
   logic                 over;

   always_comb begin
      raw  = {1'b0, a} + {1'b0, b_eff} + {{DMA_DIGIT_W{1'b0}}, cin};
      over = (raw > (DMA_DIGIT_W+1)'(DMA_DIGIT_MAX));
      if (sub) begin
         // carry out of the nibble means no borrow; otherwise pull back by 6
         cout  = raw[DMA_DIGIT_W];
         digit = raw[DMA_DIGIT_W] ? raw[DMA_DIGIT_W-1:0]
                                  : raw[DMA_DIGIT_W-1:0] - DMA_DIGIT_W'(DMA_DIGIT_ADJ);
      end else begin
         cout  = over;
         digit = over ? raw[DMA_DIGIT_W-1:0] + DMA_DIGIT_W'(DMA_DIGIT_ADJ)
                      : raw[DMA_DIGIT_W-1:0];
      end
   end
endmodule

// File: rtl/dma_dec_chain.sv
module dma_dec_chain
   import dma_pkg::*;
#(
   parameter int unsigned DIGITS = 2,
   localparam int unsigned W = DIGITS * DMA_DIGIT_W
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b_eff,
   input  logic         cin,
   input  logic         sub,
   output logic [W-1:0] res,
   output logic         cout
);
   logic [DIGITS:0] chain;

   assign chain[0] = cin;
   assign cout     = chain[DIGITS];

   for (genvar g = 0; g < DIGITS; g++) begin : g_digit
      dma_digit_fix u_fix (
         .a     (a[g*DMA_DIGIT_W +: DMA_DIGIT_W]),
         .b_eff (b_eff[g*DMA_DIGIT_W +: DMA_DIGIT_W]),
         .cin   (chain[g]),
         .sub   (sub),
         .digit (res[g*DMA_DIGIT_W +: DMA_DIGIT_W]),
         .cout  (chain[g+1])
      );
   end
endmodule

// File: rtl/dual_mode_adder.sv
module dual_mode_adder
   import dma_pkg::*;
#(
   parameter int unsigned DIGITS = 2,
   localparam int unsigned WIDTH = DIGITS * DMA_DIGIT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             dec_en,
   input  logic             sub_en,
   input  logic             carry_in,
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   output logic [WIDTH-1:0] result,
   output logic             flag_n,
   output logic             flag_v,
   output logic             flag_z,
   output logic             flag_c,
   output logic             done
);
   if (DIGITS < 1) begin : g_bad_digits
      $error("dual_mode_adder: DIGITS must be at least 1");
   end

   logic [WIDTH-1:0] b_eff;
   logic [WIDTH-1:0] bin_res;
   logic             bin_c;
   logic             bin_v;
   logic [WIDTH-1:0] dec_res;
   logic             dec_c;

   logic             busy;
   logic [WIDTH-1:0] hold_res;
   logic             hold_c;
   logic             hold_v;
   logic [WIDTH-1:0] res_q;
   dma_flags_t       flg_q;
   logic             done_q;

   assign b_eff = sub_en ? ~opb : opb;

   dma_bin_sum #(.W(WIDTH)) u_bin (
      .a     (opa),
      .b_eff (b_eff),
      .cin   (carry_in),
      .sum   (bin_res),
      .cout  (bin_c),
      .ovf   (bin_v)
   );

   dma_dec_chain #(.DIGITS(DIGITS)) u_dec (
      .a     (opa),
      .b_eff (b_eff),
      .cin   (carry_in),
      .sub   (sub_en),
      .res   (dec_res),
      .cout  (dec_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         hold_res <= '0;
         hold_c   <= 1'b0;
         hold_v   <= 1'b0;
         res_q    <= '0;
         flg_q    <= '0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (busy) begin
            // second cycle of a decimal op: flags from the corrected value
            busy    <= 1'b0;
            res_q   <= hold_res;
            flg_q.n <= hold_res[WIDTH-1];
            flg_q.z <= (hold_res == '0);
            flg_q.c <= hold_c;
            flg_q.v <= hold_v;
            done_q  <= 1'b1;
         end else if (start) begin
            if (dec_en) begin
               busy     <= 1'b1;
               hold_res <= dec_res;
               hold_c   <= dec_c;
               hold_v   <= bin_v;
            end else begin
               res_q   <= bin_res;
               flg_q.n <= bin_res[WIDTH-1];
               flg_q.z <= (bin_res == '0);
               flg_q.c <= bin_c;
               flg_q.v <= bin_v;
               done_q  <= 1'b1;
            end
         end
      end
   end

   assign result = res_q;
   assign flag_n = flg_q.n;
   assign flag_v = flg_q.v;
   assign flag_z = flg_q.z;
   assign flag_c = flg_q.c;
   assign done   = done_q;
endmodule

// File: rtl/dma_checker.sv
module dma_checker #(
   parameter int unsigned W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start,
   input logic         dec_en,
   input logic         busy,
   input logic         done,
   input logic [W-1:0] result,
   input logic         flag_n,
   input logic         flag_z
);
   // R2: binary launch completes on the next cycle
   p_bin_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !dec_en && !busy) |=> done);

   // R8: decimal launch leaves done low for one cycle
   p_dec_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (start && dec_en && !busy) |=> !done);

   // R8: decimal launch completes on the second cycle
   p_dec_finish_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> done);

   // R5: negative flag follows the presented result
   p_neg_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (flag_n == result[W-1]));

   // R5: zero flag follows the presented result
   p_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (flag_z == (result == '0)));

   // R10: result holds while done is low
   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(result));

   // R9: a start during the busy cycle does not leave the block busy
   p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> !busy);
endmodule

bind dual_mode_adder dma_checker #(.W(WIDTH)) u_dma_checker (
   .clk    (clk),
   .rst_n  (rst_n),
   .start  (start),
   .dec_en (dec_en),
   .busy   (busy),
   .done   (done),
   .result (result),
   .flag_n (flag_n),
   .flag_z (flag_z)
);

// File: tb/dual_mode_adder_bench.sv
module dual_mode_adder_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic       dec_en = 1'b0;
   logic       sub_en = 1'b0;
   logic       carry_in = 1'b0;
   logic [7:0] opa = '0;
   logic [7:0] opb = '0;
   logic [7:0] result;
   logic       flag_n, flag_v, flag_z, flag_c, done;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit run_mon = 1'b0;
   logic [7:0] last_res = '0;

   typedef struct {
      logic [7:0] res;
      logic n, v, z, c;
      int due;
      string tag;
   } exp_t;

   exp_t sb[$];

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   dual_mode_adder u_dual_mode_adder (
      .clk(clk), .rst_n(rst_n), .start(start), .dec_en(dec_en), .sub_en(sub_en),
      .carry_in(carry_in), .opa(opa), .opb(opb), .result(result),
      .flag_n(flag_n), .flag_v(flag_v), .flag_z(flag_z), .flag_c(flag_c), .done(done)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic exp_t model(input logic [7:0] a, input logic [7:0] b,
                                  input logic ci, input logic sb_, input logic dm);
      exp_t e;
      logic [7:0] be;
      logic [8:0] s;
      int da, db, t;
      be = sb_ ? ~b : b;
      s = {1'b0, a} + {1'b0, be} + {8'd0, ci};
      e.v = (a[7] == be[7]) && (s[7] != a[7]);
      if (!dm) begin
         e.res = s[7:0];
         e.c = s[8];
         e.tag = sb_ ? "R3" : "R2";
      end else begin
         da = a[7:4] * 10 + a[3:0];
         db = b[7:4] * 10 + b[3:0];
         if (!sb_) begin
            t = da + db + ci;
            e.c = (t >= 100);
            t = t % 100;
            e.tag = "R6";
         end else begin
            t = da - db - (1 - ci);
            e.c = (t >= 0);
            if (t < 0) t = t + 100;
            e.tag = "R7";
         end
         e.res = {4'(t / 10), 4'(t % 10)};
      end
      e.n = e.res[7];
      e.z = (e.res == 8'd0);
      return e;
   endfunction

   // driver: called at a negedge, returns at a negedge
   task automatic issue(input logic [7:0] a, input logic [7:0] b,
                        input logic ci, input logic sb_, input logic dm);
      exp_t e;
      e = model(a, b, ci, sb_, dm);
      e.due = cyc + (dm ? 2 : 1);
      sb.push_back(e);
      opa = a; opb = b; carry_in = ci; sub_en = sb_; dec_en = dm; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (dm) @(negedge clk);
   endtask

   function automatic logic [7:0] rnd_bcd();
      return {4'($urandom % 10), 4'($urandom % 10)};
   endfunction

   // monitor
   always @(negedge clk) begin
      if (run_mon) begin
         if (done) begin
            if (sb.size() == 0) begin
               chk(1'b0, "R9", "unexpected done", 1, 0);
            end else begin
               exp_t e;
               e = sb.pop_front();
               chk(cyc == e.due, (e.tag == "R6" || e.tag == "R7") ? "R8" : "R2",
                   "done cycle", cyc, e.due);
               chk(result == e.res, e.tag, "result", result, e.res);
               chk(flag_c == e.c, e.tag, "carry", flag_c, e.c);
               chk(flag_v == e.v, "R4", "overflow", flag_v, e.v);
               chk(flag_n == e.n, "R5", "negative", flag_n, e.n);
               chk(flag_z == e.z, "R5", "zero", flag_z, e.z);
            end
            last_res = result;
         end else begin
            chk(result == last_res, "R10", "hold", result, last_res);
         end
      end
   end

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(result == 8'd0, "R1", "result in reset", result, 0);
      chk(done == 1'b0, "R1", "done in reset", done, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk({flag_n, flag_v, flag_z, flag_c} == 4'd0, "R1", "flags after reset",
          {flag_n, flag_v, flag_z, flag_c}, 0);
      chk(done == 1'b0 && result == 8'd0, "R1", "idle after reset", done, 0);
      run_mon = 1'b1;

      // binary directed
      issue(8'h50, 8'h50, 1'b0, 1'b0, 1'b0);   // R4 overflow
      issue(8'hFF, 8'h01, 1'b0, 1'b0, 1'b0);   // R2 wrap to zero, carry
      issue(8'h50, 8'hB0, 1'b1, 1'b1, 1'b0);   // R3 signed overflow on subtract
      issue(8'h00, 8'h01, 1'b1, 1'b1, 1'b0);   // R3 borrow
      issue(8'h10, 8'h10, 1'b0, 1'b1, 1'b0);   // R3 carry_in=0 borrows one more
      // decimal directed
      issue(8'h58, 8'h46, 1'b1, 1'b0, 1'b1);   // R6 both digits corrected
      issue(8'h99, 8'h01, 1'b0, 1'b0, 1'b1);   // R6 wrap to zero
      issue(8'h45, 8'h35, 1'b0, 1'b0, 1'b1);   // R5 corrected bit 7 set
      issue(8'h00, 8'h01, 1'b1, 1'b1, 1'b1);   // R7 borrow wraps to 99
      issue(8'h50, 8'h25, 1'b1, 1'b1, 1'b1);   // R7
      issue(8'h50, 8'h25, 1'b0, 1'b1, 1'b1);   // R7 carry_in=0
      // back-to-back binary
      issue(8'h7F, 8'h01, 1'b0, 1'b0, 1'b0);
      issue(8'h80, 8'h01, 1'b0, 1'b1, 1'b0);

      // R9: start during busy cycle is ignored
      begin
         exp_t e;
         e = model(8'h27, 8'h38, 1'b0, 1'b0, 1'b1);
         e.due = cyc + 2;
         sb.push_back(e);
         opa = 8'h27; opb = 8'h38; carry_in = 1'b0; sub_en = 1'b0; dec_en = 1'b1;
         start = 1'b1;
         @(negedge clk);
         opa = 8'hAA; opb = 8'h11; dec_en = 1'b0;   // stays high in busy cycle
         @(negedge clk);
         start = 1'b0;
         repeat (2) @(negedge clk);
      end

      // random valid BCD and binary mix
      for (int i = 0; i < 60; i++) begin
         logic dm, sb_;
         dm = 1'($urandom);
         sb_ = 1'($urandom);
         if (dm) issue(rnd_bcd(), rnd_bcd(), 1'($urandom), sb_, 1'b1);
         else    issue(8'($urandom), 8'($urandom), 1'($urandom), sb_, 1'b0);
         if (i % 7 == 0) @(negedge clk);
      end

      repeat (4) @(negedge clk);
      chk(sb.size() == 0, "R10", "missing results", sb.size(), 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule